// File: doc/BRIEF.md
# Multiplexed Bus Slave Address Front End

This block is the address-phase front end of a slave card on a 32-bit bus whose upper address lines also carry data. The bus master places the full address, a read flag and a 3-bit space code on the bus and then pulls the active-low full-cycle strobe low. Shortly after that edge the upper address lines float. The block therefore captures address bits 31..8 together with the strobe edge and holds them until the strobe rises again. Address bits 7..2 and the space code stay valid for the whole cycle, so they are passed through directly.

The strobes are asynchronous to the card clock. Both pass through a two-flop synchronizer, and the bus pins are delayed alongside them so that the captured values belong to the sample in which the strobe was first seen low. The space code is classified as a memory access, an interrupt-type access or a reserved code that gets no response. Memory accesses are checked against two configuration windows: a native one and a legacy one qualified by the legacy address strobe. All other memory accesses are compared against a base value that is loaded through a small write port. The base match stays off until that base has been written once.

Top module: `mbus_slave_front`

## Requirements
- R1: After reset, `act_o`, `rd_o`, `addr_o`, `cls_o`, `cfg_o`, `cfg_leg_o` and `match_o` are all 0.
- R2: On a falling edge of `full_n`, `act_o` rises on the third rising clock edge. From then on `addr_o[31:8]` holds the value `addr_i[31:8]` had at the first of those edges, even when the pins change afterwards.
- R3: While `act_o` is high, `addr_o[7:2]` follows `addr_i[7:2]` directly. `rd_o` holds the `rd_i` value that was captured with the address (1 = read, 0 = write).
- R4: `space_i` is written as {FC0,FC1,FC2}. Codes 3'b001, 3'b010, 3'b101 and 3'b110 give `cls_o` = 2'b01 (memory).
- R5: Code 3'b111 gives `cls_o` = 2'b10 (interrupt-type) and never produces `cfg_o` or `match_o`.
- R6: Codes 3'b000, 3'b011 and 3'b100 give `cls_o` = 2'b00 (no response), with `cfg_o` and `match_o` low.
- R7: A memory access with captured address bits 31..16 equal to 16'hFF00 sets `cfg_o` = 1 and `cfg_leg_o` = 0, and suppresses `match_o`.
- R8: A memory access with `leg_n` low at capture and address bits 23..16 equal to 8'hE8 sets `cfg_o` = 1 and `cfg_leg_o` = 1, whatever bits 31..24 are. The same address with `leg_n` high is not a configuration access.
- R9: `leg_n` going low while `full_n` stays high is a legacy-master cycle. It is ignored, and `act_o`, `cfg_o` and `match_o` stay 0.
- R10: `match_o` is 1 only for an active memory, non-configuration access whose captured bits 31..24 equal the base loaded by `base_we`/`base_wd`. Before the first base write, `match_o` stays 0.
- R11: On a rising edge of `full_n`, all outputs return to 0 on the third rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_n | input | 1 | Full-cycle strobe, active low, asynchronous |
| leg_n | input | 1 | Legacy address strobe, active low, asynchronous |
| rd_i | input | 1 | Read flag from the bus, 1 = read |
| addr_i | input | 30 | Bus address bits 31..2 |
| space_i | input | 3 | Space code {FC0,FC1,FC2} |
| base_we | input | 1 | Base write strobe |
| base_wd | input | 8 | Base value for address bits 31..24 |
| act_o | output | 1 | A captured cycle is in progress |
| rd_o | output | 1 | Captured read flag |
| addr_o | output | 30 | Captured upper bits and live lower bits |
| cls_o | output | 2 | 00 none, 01 memory, 10 interrupt-type |
| cfg_o | output | 1 | Configuration window hit |
| cfg_leg_o | output | 1 | The hit is in the legacy window |
| match_o | output | 1 | Access to the card's assigned base |

## Verification
Every captured result is due exactly three rising edges after the strobe falls, and the idle state is due three edges after it rises. The driver changes pins only on falling clock edges. It confirms that `act_o` is still low two falling edges after driving the strobe low, and it pushes the expected record into a queue. The monitor pops that record on the falling edge where `act_o` first reads high, so a result that comes early, late or unrequested is reported. The upper address pins are overwritten with a different value one cycle after the strobe falls, which shows that the held value came from the capture sample.

// File: rtl/mbus_slave_front.sv
module mbus_slave_front #(
  parameter int AW = 32,
  parameter int LO_W = 8,
  parameter int BASE_W = 8,
  parameter logic [15:0] NATIVE_CFG = 16'hFF00,
  parameter logic [7:0] LEGACY_CFG = 8'hE8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_n,
  input  logic              leg_n,
  input  logic              rd_i,
  input  logic [AW-1:2]     addr_i,
  input  logic [2:0]        space_i,
  input  logic              base_we,
  input  logic [BASE_W-1:0] base_wd,
  output logic              act_o,
  output logic              rd_o,
  output logic [AW-1:2]     addr_o,
  output logic [1:0]        cls_o,
  output logic              cfg_o,
  output logic              cfg_leg_o,
  output logic              match_o
);
  localparam int HW = AW - LO_W;
  localparam int LW = LO_W - 2;
  localparam int PW = HW + 4;
  localparam logic [1:0] C_NONE = 2'b00, C_MEM = 2'b01, C_INT = 2'b10;

  logic [2:0]        fs;
  logic [1:0]        ls;
  logic [PW-1:0]     p1, p2;
  logic [HW-1:0]     hi_q;
  logic [BASE_W-1:0] base_q;
  logic              cfgd_q, act_q, rd_q, nat_q, leg_q;
  logic [1:0]        cls_q, cls_n;
  logic              fall, rise;
  logic [HW-1:0]     p_hi;
  logic [2:0]        p_sp;

  assign fall = !fs[1] && fs[2];
  assign rise = fs[1] && !fs[2];
  assign p_hi = p2[PW-1 -: HW];
  assign p_sp = p2[2:0];

  always_comb begin
    case (p_sp)
      3'b001, 3'b010, 3'b101, 3'b110: cls_n = C_MEM;
      3'b111:                         cls_n = C_INT;
      default:                        cls_n = C_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs <= 3'b111;
      ls <= 2'b11;
      p1 <= '0;
      p2 <= '0;
    end else begin
      fs <= {fs[1:0], full_n};
      ls <= {ls[0], leg_n};
      p1 <= {addr_i[AW-1:LO_W], rd_i, space_i};
      p2 <= p1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      cfgd_q <= 1'b0;
    end else if (base_we) begin
      base_q <= base_wd;
      cfgd_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      hi_q  <= '0;
      rd_q  <= 1'b0;
      cls_q <= C_NONE;
      nat_q <= 1'b0;
      leg_q <= 1'b0;
    end else if (fall) begin
      act_q <= 1'b1;
      hi_q  <= p_hi;
      rd_q  <= p2[3];
      cls_q <= cls_n;
      nat_q <= (cls_n == C_MEM) && (p_hi[HW-1 -: 16] == NATIVE_CFG);
      leg_q <= (cls_n == C_MEM) && !ls[1] && (p_hi[HW-9 -: 8] == LEGACY_CFG);
    end else if (rise) begin
      act_q <= 1'b0;
      hi_q  <= '0;
      rd_q  <= 1'b0;
      cls_q <= C_NONE;
      nat_q <= 1'b0;
      leg_q <= 1'b0;
    end
  end

  assign act_o     = act_q;
  assign rd_o      = rd_q;
  assign addr_o    = {hi_q, act_q ? addr_i[LO_W-1:2] : {LW{1'b0}}};
  assign cls_o     = cls_q;
  assign cfg_o     = nat_q || leg_q;
  assign cfg_leg_o = leg_q;
  assign match_o   = act_q && cfgd_q && (cls_q == C_MEM) && !cfg_o
                     && (hi_q[HW-1 -: BASE_W] == base_q);

  a_r2_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (act_o && $past(act_o) && !rise && !$past(rise)) |-> $stable(addr_o[AW-1:LO_W]));
  a_r6_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_o == C_NONE) |-> (!match_o && !cfg_o));
  a_r5_int_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_o == C_INT) |-> (!match_o && !cfg_o));
  a_r8_leg_is_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_leg_o |-> cfg_o);
  a_r9_no_start_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_o && fs[1] && fs[2]) |=> !act_o);
  a_r10_unconfigured: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgd_q |-> !match_o);
  a_r11_match_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> act_o);
  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (!act_o && cls_o == C_NONE));
endmodule

// File: tb/mbus_slave_front_tb.sv
module mbus_slave_front_tb_top;
  typedef struct packed {
    logic [23:0] hi;
    logic [5:0]  lo;
    logic        rd;
    logic [1:0]  cls;
    logic        cfg;
    logic        leg;
    logic        match;
  } exp_t;

  logic clk = 0, rst_n = 0, full_n = 1, leg_n = 1, rd_i = 0, base_we = 0;
  logic [31:2] addr_i = '0;
  logic [2:0]  space_i = '0;
  logic [7:0]  base_wd = '0;
  logic act_o, rd_o, cfg_o, cfg_leg_o, match_o;
  logic [31:2] addr_o;
  logic [1:0]  cls_o;

  int checks = 0, errors = 0;
  exp_t q[$];
  logic act_prev = 0;
  logic tb_cfgd = 0;
  logic [7:0] tb_base = '0;

  always #10 clk = ~clk;

  mbus_slave_front dut_i (
    .clk(clk), .rst_n(rst_n), .full_n(full_n), .leg_n(leg_n), .rd_i(rd_i),
    .addr_i(addr_i), .space_i(space_i), .base_we(base_we), .base_wd(base_wd),
    .act_o(act_o), .rd_o(rd_o), .addr_o(addr_o), .cls_o(cls_o), .cfg_o(cfg_o),
    .cfg_leg_o(cfg_leg_o), .match_o(match_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic exp_t model(logic [31:2] a, logic rd, logic [2:0] sp, logic legl);
    exp_t e;
    logic mem;
    e.hi = a[31:8];
    e.lo = a[7:2];
    e.rd = rd;
    case (sp)
      3'b001, 3'b010, 3'b101, 3'b110: e.cls = 2'b01;
      3'b111: e.cls = 2'b10;
      default: e.cls = 2'b00;
    endcase
    mem = (e.cls == 2'b01);
    e.leg = mem && legl && (a[23:16] == 8'hE8);
    e.cfg = e.leg || (mem && a[31:16] == 16'hFF00);
    e.match = tb_cfgd && mem && !e.cfg && (a[31:24] == tb_base);
    return e;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (act_o && !act_prev) begin
        if (q.size() == 0) chk(0, "R2 unexpected start", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(addr_o[31:8] == e.hi, "R2 addr_hi", addr_o[31:8], e.hi);
          chk(addr_o[7:2] == e.lo, "R3 addr_lo", addr_o[7:2], e.lo);
          chk(rd_o == e.rd, "R3 rd", rd_o, e.rd);
          chk(cls_o == e.cls, "R4 R5 R6 cls", cls_o, e.cls);
          chk(cfg_o == e.cfg, "R7 R8 cfg", cfg_o, e.cfg);
          chk(cfg_leg_o == e.leg, "R8 cfg_leg", cfg_leg_o, e.leg);
          chk(match_o == e.match, "R10 match", match_o, e.match);
        end
      end
      act_prev = act_o;
    end
  end

  task automatic load_base(input logic [7:0] b);
    @(negedge clk);
    base_we = 1; base_wd = b;
    @(negedge clk);
    base_we = 0;
    tb_cfgd = 1; tb_base = b;
  endtask

  task automatic bus_cycle(input logic [31:2] a, input logic rd, input logic [2:0] sp, input logic legl);
    @(negedge clk);
    addr_i = a; rd_i = rd; space_i = sp; leg_n = !legl;
    @(negedge clk);
    full_n = 0;
    q.push_back(model(a, rd, sp, legl));
    @(negedge clk);
    addr_i[31:8] = ~a[31:8];
    @(negedge clk);
    chk(act_o == 0, "R2 latency", act_o, 0);
    repeat (4) @(negedge clk);
    chk(addr_o[7:2] == a[7:2], "R3 lo live", addr_o[7:2], a[7:2]);
    full_n = 1; leg_n = 1;
    repeat (2) @(negedge clk);
    chk(act_o == 1, "R11 release latency", act_o, 1);
    @(negedge clk);
    chk({act_o, cls_o, cfg_o, match_o, addr_o} == '0, "R11 idle", {act_o, cls_o, cfg_o, match_o}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({act_o, rd_o, addr_o, cls_o, cfg_o, cfg_leg_o, match_o} == '0, "R1 reset", addr_o, 0);
    rst_n = 1;
    bus_cycle({8'h42, 16'h1234, 6'h05}, 1, 3'b001, 0);
    load_base(8'h42);
    bus_cycle({8'h42, 16'h1234, 6'h05}, 1, 3'b001, 0);
    bus_cycle({8'h42, 16'h0010, 6'h3F}, 0, 3'b010, 0);
    bus_cycle({8'h42, 16'h5555, 6'h2A}, 1, 3'b101, 0);
    bus_cycle({8'h42, 16'hAAAA, 6'h11}, 0, 3'b110, 0);
    bus_cycle({8'h41, 16'h1234, 6'h05}, 1, 3'b001, 0);
    bus_cycle({8'h42, 16'h0000, 6'h01}, 1, 3'b111, 0);
    bus_cycle({8'h42, 16'h0000, 6'h02}, 1, 3'b000, 0);
    bus_cycle({8'h42, 16'h0000, 6'h03}, 0, 3'b011, 0);
    bus_cycle({8'h42, 16'h0000, 6'h04}, 1, 3'b100, 0);
    bus_cycle({8'hFF, 16'h0000, 6'h10}, 1, 3'b101, 0);
    bus_cycle({8'h00, 16'hE800, 6'h12}, 1, 3'b101, 1);
    bus_cycle({8'h42, 16'hE800, 6'h13}, 0, 3'b001, 1);
    bus_cycle({8'h42, 16'hE800, 6'h14}, 1, 3'b001, 0);
    @(negedge clk);
    addr_i = {8'h42, 16'h0000, 6'h01}; space_i = 3'b001; leg_n = 0;
    repeat (8) @(negedge clk);
    chk({act_o, cfg_o, match_o} == 0, "R9 legacy master ignored", {act_o, cfg_o, match_o}, 0);
    leg_n = 1;
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R2 pending results", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule